// File: doc/BRIEF.md
# Processor Status Register and Supervisor Trap Unit

This block keeps the processor's 32-bit live status word and one saved copy of it for supervisor mode. Three kinds of request arrive on its request port: copy a status word out to a register, load a status word from a register value or a 32-bit immediate, and enter the supervisor trap. The low five bits of the live word hold the execution mode. The top four bits hold the condition flags. Bit 7 masks normal interrupts and bit 6 masks fast interrupts.

How much of a word may be written depends on the current mode. In user mode only the four flag bits of the live word can change, and the saved copy can be neither read nor written. Privileged code may replace either word in full, unless it asks for the flags-only form or supplies an immediate. Either of those narrows the write to the flag bits. A trap request does its whole job on one clock edge. The live word is copied into the saved copy. The mode becomes supervisor and normal interrupts are masked. The return address is issued for the supervisor link register, and the fetch unit is told to restart at a fixed vector.

All results come from registers and appear on the cycle after the request. Read data stays on `rd_data` until the next read. The new fetch address and the link value stay on their ports until the next trap. The redirect strobe is high for exactly one cycle.

Top module: `psr_trap_unit`

## Requirements
- R1: A read request (`req_op`=01) with `req_target`=0 returns the live status word on `rd_data` one cycle later, in any mode.
- R2: A read request with `req_target`=1 returns the saved word in a privileged mode. In user mode (mode bits 4:0 = 10000) it returns zero.
- R3: In user mode a write request (`req_op`=10) to the live word changes only bits 31:28 and leaves bits 27:0 unchanged.
- R4: In a privileged mode (any mode other than 10000), a write with `req_flags_only`=0 and `req_imm`=0 replaces the selected word in full.
- R5: In a privileged mode, a write with `req_flags_only`=1 changes only bits 31:28 of the selected word.
- R6: A write with `req_imm`=1 changes only bits 31:28 of the selected word, in every mode.
- R7: In user mode a write aimed at the saved word changes neither the saved word nor the live word.
- R8: A trap request (`req_op`=11) copies the live word into the saved word. In the live word it sets the mode to 10011 and sets bit 7, and it keeps every other bit.
- R9: One cycle after a trap request, `pc_redirect` is 1, `pc_next` is 0x08 and `link_value` is `pc_in`+4, where `pc_in` is the value sampled with the request.
- R10: After reset the live word is 0x000000D3 (supervisor, both interrupt masks set, flags clear), the saved word is 0, and `rd_data` and `pc_redirect` are 0.
- R11: `pc_redirect` is 1 only on the cycle after a trap request. An idle request (`req_op`=00) changes neither status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 2 | 00 idle, 01 read, 10 write, 11 trap |
| req_target | input | 1 | 0 live word, 1 saved word |
| req_flags_only | input | 1 | Limit a privileged write to bits 31:28 |
| req_imm | input | 1 | Write data is an immediate (flag bits only) |
| wr_data | input | 32 | Write data |
| pc_in | input | 32 | Address of the current instruction |
| rd_data | output | 32 | Result of the last read |
| pc_next | output | 32 | Restart address after a trap |
| pc_redirect | output | 1 | One-cycle strobe telling the fetch unit to restart |
| link_value | output | 32 | Return address for the supervisor link register |

## Verification
User mode can be entered only through a privileged full write that rewrites the mode field. It can be left only through a trap, because user writes cannot reach the mode bits. The sweep therefore drives the mode in and out many times, and a trap is the only exit. A user-mode write aimed at the saved word cannot be seen at the ports. A user read of that word returns zero, and the trap that leaves user mode overwrites the saved word. For that case the bench checks that the live word and the read result are unchanged, and a bound property checks that the saved word stays stable.

// File: rtl/psru_pkg.sv
package psru_pkg;

    localparam int MODE_W       = 5;
    localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_SUPV = 5'b10011;
    localparam int IRQ_MASK_BIT = 7;
    localparam int FIQ_MASK_BIT = 6;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_TRAP  = 2'b11
    } op_e;

    typedef enum logic {
        TGT_LIVE  = 1'b0,
        TGT_SAVED = 1'b1
    } tgt_e;

    typedef struct packed {
        op_e  op;
        tgt_e tgt;
        logic flags_only;
        logic imm_form;
    } req_t;

    function automatic logic mode_is_user(input logic [MODE_W-1:0] m);
        return m == MODE_USER;
    endfunction

    function automatic logic narrow_write(input logic user, input logic flags_only,
                                          input logic imm_form);
        return user | flags_only | imm_form;
    endfunction

endpackage

// File: rtl/psru_access_ctl.sv
module psru_access_ctl
    import psru_pkg::*;
#(
    parameter int DW     = 32,
    parameter int FLAG_W = 4
) (
    input  req_t          req,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] live,
    input  logic [DW-1:0] saved,
    output logic          live_we,
    output logic          saved_we,
    output logic [DW-1:0] live_nxt,
    output logic [DW-1:0] saved_nxt,
    output logic          rd_en,
    output logic [DW-1:0] rd_val
);
    localparam logic [DW-1:0] FLAG_MASK = {{FLAG_W{1'b1}}, {(DW-FLAG_W){1'b0}}};

    logic          user;
    logic          is_wr;
    logic [DW-1:0] mask;

    always_comb begin
        user      = mode_is_user(live[MODE_W-1:0]);
        is_wr     = (req.op == OP_WRITE);
        mask      = narrow_write(user, req.flags_only, req.imm_form) ? FLAG_MASK : '1;
        live_we   = is_wr && (req.tgt == TGT_LIVE);
        saved_we  = is_wr && (req.tgt == TGT_SAVED) && !user;
        live_nxt  = (live  & ~mask) | (wr_data & mask);
        saved_nxt = (saved & ~mask) | (wr_data & mask);
        rd_en     = (req.op == OP_READ);
        if (req.tgt == TGT_LIVE)
            rd_val = live;
        else if (user)
            rd_val = '0;
        else
            rd_val = saved;
    end

endmodule

// File: rtl/psru_trap_gen.sv
module psru_trap_gen
    import psru_pkg::*;
#(
    parameter int            DW       = 32,
    parameter logic [DW-1:0] LINK_OFS = 32'd4
) (
    input  logic [DW-1:0] live,
    input  logic [DW-1:0] pc,
    output logic [DW-1:0] live_trap,
    output logic [DW-1:0] link
);
    always_comb begin
        live_trap                 = live;
        live_trap[MODE_W-1:0]     = MODE_SUPV;
        live_trap[IRQ_MASK_BIT]   = 1'b1;
        link                      = pc + LINK_OFS;
    end

endmodule

// File: rtl/psru_status_reg.sv
module psru_status_reg #(
    parameter int            DW      = 32,
    parameter logic [DW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_a,
    input  logic [DW-1:0] val_a,
    input  logic          load_b,
    input  logic [DW-1:0] val_b,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (load_a)
            q <= val_a;
        else if (load_b)
            q <= val_b;
    end

endmodule

// File: rtl/psr_trap_unit.sv
module psr_trap_unit
    import psru_pkg::*;
#(
    parameter int            DW       = 32,
    parameter int            FLAG_W   = 4,
    parameter logic [DW-1:0] TRAP_VEC = 32'h0000_0008,
    parameter logic [DW-1:0] LINK_OFS = 32'd4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    req_op,
    input  logic          req_target,
    input  logic          req_flags_only,
    input  logic          req_imm,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] pc_next,
    output logic          pc_redirect,
    output logic [DW-1:0] link_value
);
    localparam logic [DW-1:0] LIVE_RST =
        DW'({1'b1, 1'b1, 1'b0, MODE_SUPV}) | (DW'(1) << IRQ_MASK_BIT) | (DW'(1) << FIQ_MASK_BIT);

    req_t          req;
    logic          is_trap;
    logic          live_we, saved_we, rd_en;
    logic [DW-1:0] live_q, saved_q;
    logic [DW-1:0] live_nxt, saved_nxt, rd_val;
    logic [DW-1:0] live_trap, link;

    assign req     = '{op: op_e'(req_op), tgt: tgt_e'(req_target),
                       flags_only: req_flags_only, imm_form: req_imm};
    assign is_trap = (req.op == OP_TRAP);

    psru_access_ctl #(.DW(DW), .FLAG_W(FLAG_W)) u_access (
        .req       (req),
        .wr_data   (wr_data),
        .live      (live_q),
        .saved     (saved_q),
        .live_we   (live_we),
        .saved_we  (saved_we),
        .live_nxt  (live_nxt),
        .saved_nxt (saved_nxt),
        .rd_en     (rd_en),
        .rd_val    (rd_val)
    );

    psru_trap_gen #(.DW(DW), .LINK_OFS(LINK_OFS)) u_trap (
        .live      (live_q),
        .pc        (pc_in),
        .live_trap (live_trap),
        .link      (link)
    );

    // Trap takes priority; a trap and a write never share a cycle since op is one code.
    psru_status_reg #(.DW(DW), .RST_VAL(LIVE_RST)) u_live (
        .clk    (clk),
        .rst    (rst),
        .load_a (is_trap),
        .val_a  (live_trap),
        .load_b (live_we),
        .val_b  (live_nxt),
        .q      (live_q)
    );

    psru_status_reg #(.DW(DW), .RST_VAL('0)) u_saved (
        .clk    (clk),
        .rst    (rst),
        .load_a (is_trap),
        .val_a  (live_q),
        .load_b (saved_we),
        .val_b  (saved_nxt),
        .q      (saved_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data     <= '0;
            pc_next     <= '0;
            pc_redirect <= 1'b0;
            link_value  <= '0;
        end else begin
            pc_redirect <= is_trap;
            if (rd_en)
                rd_data <= rd_val;
            if (is_trap) begin
                pc_next    <= TRAP_VEC;
                link_value <= link;
            end
        end
    end

endmodule

// File: rtl/psr_trap_unit_chk.sv
module psr_trap_unit_chk
    import psru_pkg::*;
#(
    parameter int            DW       = 32,
    parameter logic [DW-1:0] TRAP_VEC = 32'h8,
    parameter logic [DW-1:0] LINK_OFS = 32'd4
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    req_op,
    input logic          req_target,
    input logic          req_flags_only,
    input logic          req_imm,
    input logic [DW-1:0] pc_in,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] pc_next,
    input logic          pc_redirect,
    input logic [DW-1:0] link_value,
    input logic [DW-1:0] live_q,
    input logic [DW-1:0] saved_q
);
    logic user;
    assign user = mode_is_user(live_q[MODE_W-1:0]);

    p_trap_outputs_r9: assert property (@(posedge clk) disable iff (rst)
        req_op == OP_TRAP |=> pc_redirect && pc_next == TRAP_VEC
                              && link_value == $past(pc_in) + LINK_OFS);

    p_redirect_only_trap_r11: assert property (@(posedge clk) disable iff (rst)
        pc_redirect |-> $past(req_op) == OP_TRAP);

    p_trap_state_r8: assert property (@(posedge clk) disable iff (rst)
        req_op == OP_TRAP |=> live_q[MODE_W-1:0] == MODE_SUPV && live_q[IRQ_MASK_BIT]
                              && saved_q == $past(live_q)
                              && live_q[DW-1:8] == $past(live_q[DW-1:8]));

    p_user_live_flags_r3: assert property (@(posedge clk) disable iff (rst)
        (req_op == OP_WRITE && req_target == 1'b0 && user)
            |=> live_q[DW-5:0] == $past(live_q[DW-5:0]));

    p_user_saved_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (req_op == OP_WRITE && req_target == 1'b1 && user) |=> $stable(saved_q) && $stable(live_q));

    p_user_saved_read_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (req_op == OP_READ && req_target == 1'b1 && user) |=> rd_data == '0);

    p_narrow_write_r5: assert property (@(posedge clk) disable iff (rst)
        (req_op == OP_WRITE && req_target == 1'b0 && (req_flags_only || req_imm))
            |=> live_q[DW-5:0] == $past(live_q[DW-5:0]));

    p_idle_stable_r11: assert property (@(posedge clk) disable iff (rst)
        req_op == OP_IDLE |=> $stable(live_q) && $stable(saved_q));

endmodule

bind psr_trap_unit psr_trap_unit_chk #(.DW(DW), .TRAP_VEC(TRAP_VEC), .LINK_OFS(LINK_OFS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_op         (req_op),
    .req_target     (req_target),
    .req_flags_only (req_flags_only),
    .req_imm        (req_imm),
    .pc_in          (pc_in),
    .rd_data        (rd_data),
    .pc_next        (pc_next),
    .pc_redirect    (pc_redirect),
    .link_value     (link_value),
    .live_q         (live_q),
    .saved_q        (saved_q)
);

// File: tb/test_psr_trap_unit.sv
module test_psr_trap_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  req_op;
    logic        req_target, req_flags_only, req_imm;
    logic [31:0] wr_data, pc_in;
    logic [31:0] rd_data, pc_next, link_value;
    logic        pc_redirect;

    always #10 clk = ~clk;

    psr_trap_unit i_psr_trap_unit (
        .clk(clk), .rst(rst), .req_op(req_op), .req_target(req_target),
        .req_flags_only(req_flags_only), .req_imm(req_imm), .wr_data(wr_data),
        .pc_in(pc_in), .rd_data(rd_data), .pc_next(pc_next),
        .pc_redirect(pc_redirect), .link_value(link_value)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [31:0] m_live, m_saved;

    function automatic bit is_user(input logic [31:0] w);
        return w[4:0] == 5'b10000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic drive(input logic [1:0] op, input logic tgt, input logic fo,
                         input logic im, input logic [31:0] d, input logic [31:0] pc);
        req_op = op; req_target = tgt; req_flags_only = fo; req_imm = im;
        wr_data = d; pc_in = pc;
        @(posedge clk);
        @(negedge clk);
        req_op = 2'b00;
    endtask

    task automatic do_read(input logic tgt, input string req);
        logic [31:0] exp;
        exp = (tgt == 1'b0) ? m_live : (is_user(m_live) ? 32'h0 : m_saved);
        drive(2'b01, tgt, 1'b0, 1'b0, 32'h0, 32'h0);
        check(req, rd_data, exp);
    endtask

    task automatic do_write(input logic tgt, input logic fo, input logic im, input logic [31:0] d);
        logic [31:0] mask;
        mask = (is_user(m_live) || fo || im) ? 32'hF000_0000 : 32'hFFFF_FFFF;
        if (tgt == 1'b0)
            m_live = (m_live & ~mask) | (d & mask);
        else if (!is_user(m_live))
            m_saved = (m_saved & ~mask) | (d & mask);
        drive(2'b10, tgt, fo, im, d, 32'h0);
        check("R11 no redirect on write", {31'h0, pc_redirect}, 32'h0);
    endtask

    task automatic do_trap(input logic [31:0] pc);
        m_saved = m_live;
        m_live[4:0] = 5'b10011;
        m_live[7] = 1'b1;
        drive(2'b11, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF, pc);
        check("R9 redirect strobe", {31'h0, pc_redirect}, 32'h1);
        check("R9 vector", pc_next, 32'h0000_0008);
        check("R9 link", link_value, pc + 32'd4);
        drive(2'b00, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
        check("R11 strobe one cycle", {31'h0, pc_redirect}, 32'h0);
        do_read(1'b0, "R8 live after trap");
        do_read(1'b1, "R8 saved after trap");
    endtask

    task automatic set_mode(input logic [4:0] m, input logic [31:0] pat);
        if (is_user(m_live))
            do_trap(pat ^ 32'h0000_1000);
        do_write(1'b0, 1'b0, 1'b0, {pat[31:5], m});
    endtask

    initial begin
        logic [4:0] modes [3];
        modes[0] = 5'b10011; modes[1] = 5'b10000; modes[2] = 5'b10010;
        rst = 1'b1; req_op = 2'b00; req_target = 1'b0; req_flags_only = 1'b0;
        req_imm = 1'b0; wr_data = '0; pc_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 rd_data at reset", rd_data, 32'h0);
        check("R10 redirect at reset", {31'h0, pc_redirect}, 32'h0);
        rst = 1'b0;
        m_live = 32'h0000_00D3;
        m_saved = 32'h0;
        do_read(1'b0, "R10 live reset value");
        do_read(1'b1, "R10 saved reset value");

        // idle cycles leave both words alone
        drive(2'b00, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h40);
        check("R11 no redirect on idle", {31'h0, pc_redirect}, 32'h0);
        do_read(1'b0, "R11 live after idle");
        do_read(1'b1, "R11 saved after idle");

        // sweep of modes, targets, write forms and data patterns
        for (int mi = 0; mi < 3; mi++)
            for (int t = 0; t < 2; t++)
                for (int f = 0; f < 2; f++)
                    for (int i = 0; i < 2; i++)
                        for (int k = 0; k < 4; k++) begin
                            logic [31:0] d;
                            string tag;
                            d = 32'h9E37_79B9 * (k + 1) + 32'h0101_0101 * (mi + t);
                            set_mode(modes[mi], ~d);
                            if (is_user(m_live))
                                tag = (t == 1) ? "R7 user saved write" : "R3 user live write";
                            else if (i == 1)
                                tag = "R6 immediate write";
                            else if (f == 1)
                                tag = "R5 flags-only write";
                            else
                                tag = "R4 full write";
                            do_write(t[0], f[0], i[0], d);
                            do_read(1'b0, (t == 0) ? tag : "R1 live read");
                            do_read(1'b1, is_user(m_live) ? "R2 user saved read" : tag);
                        end

        // trap from supervisor with flags set, then from user mode
        set_mode(5'b10011, 32'hA000_0040);
        do_trap(32'h0000_2000);
        set_mode(5'b10000, 32'h5000_0000);
        do_write(1'b0, 1'b0, 1'b0, 32'h3000_00D3);
        do_read(1'b0, "R3 user cannot change mode");
        do_trap(32'hFFFF_FFFC);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule